// File: doc/BRIEF.md
# Infrared SIR Serial Frame Modem

This block sits between a byte stream and an infrared emitter/detector pair. Each byte to send becomes a ten-cell asynchronous frame: a start cell, eight data cells in ascending bit order, and a stop cell. Every cell that carries a logic 0, the start cell included, gets one short high pulse on the emitter line. A cell that carries a logic 1, the stop cell included, leaves the line low. Pulse length is either a fixed three baud ticks or a programmed count of ticks.

On the receive side the detector line is synchronised and can be inverted for active-low optics. The first pulse after idle is taken as the start bit and sets the bit timing, and the byte is rebuilt from the pulses that follow. The byte is presented with a one-cycle valid strobe. A framing-error flag goes with the strobe when the stop cell also carried a pulse.

Timing comes from `baud_tick`, a one-cycle strobe at sixteen times the bit rate. Strobes must be at least four clock cycles apart. The transmit input follows valid/ready rules. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_data` must hold steady while `tx_valid` is high and the byte has not yet been taken. The sender may hold `tx_valid` high for as long as it likes. The receive output has no back-pressure, so each strobe must be consumed in the cycle it appears.

Top module: `irda_sir_modem`

## Requirements
- R1: After reset `tx_ready` is 1 and `ir_tx` is 0. `tx_ready` drops in the cycle after a byte is taken and stays low until the last tick of that frame's stop cell, and the cells go out as start (0), data bit 0 through bit 7, stop (1).
- R2: A cell of value 0 drives `ir_tx` high starting in the cycle after that cell's 8th baud tick (cell position 8 of 0..15). A cell of value 1 and an idle line keep `ir_tx` low.
- R3: With `cfg_width_var` = 0 the pulse lasts exactly 3 baud ticks, covering cell positions 8, 9 and 10.
- R4: With `cfg_width_var` = 1 the pulse lasts `cfg_width` ticks, and a value of 0 gives 1 tick.
- R5: A programmed width of more than 8 ticks ends the pulse at the end of its cell, so a pulse never reaches the next cell.
- R6: While `tx_valid` stays high, `tx_ready` is high for exactly one cycle between frames, and the next start cell begins with no extra tick.
- R7: A received frame, with `cfg_rx_invert` = 0 and high pulses, yields the byte with bit 0 taken from the first data cell. `rx_valid` is high for one cycle, in the cycle after the last tick of the stop cell.
- R8: With `cfg_rx_invert` = 1 (applied during reset) the receiver accepts low pulses on an idle-high line and decodes them the same way as R7.
- R9: A pulse inside the stop cell still delivers the byte and raises `rx_frm_err` together with `rx_valid`. Otherwise `rx_frm_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe at 16x bit rate |
| cfg_width_var | input | 1 | 1 selects programmed pulse width |
| cfg_width | input | 8 | Programmed pulse width in baud ticks |
| cfg_rx_invert | input | 1 | 1 inverts the detector line before decoding |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte is offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| ir_tx | output | 1 | Emitter drive, high = on |
| ir_rx | input | 1 | Detector line (asynchronous) |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe with a new byte |
| rx_frm_err | output | 1 | Stop cell held a pulse |

## Verification
The block's own transmitter never emits a pulse in a stop cell, and it never drives an active-low line. Framing errors and inverted reception therefore cannot be reached by looping `ir_tx` back to `ir_rx`. The bench switches `ir_rx` to a scripted pulse source that counts baud ticks and places pulses at cell midpoints. The scripted frames can carry a pulse in the stop cell, and they can use either polarity, with the polarity set while reset is asserted. Truncated and zero widths are reached by reprogramming `cfg_width` between frames, while the loopback keeps checking that the decoded byte is unchanged.

// File: rtl/irda_pkg.sv
package irda_pkg;
  localparam int unsigned OSR_DEF     = 16;
  localparam int unsigned FIXED_WIDTH = 3;
  localparam int unsigned DATA_BITS   = 8;
  localparam int unsigned FRAME_CELLS = DATA_BITS + 2;
  localparam int unsigned CELL_IDX_W  = $clog2(FRAME_CELLS);

  typedef enum logic {
    RX_HUNT = 1'b0,
    RX_CELL = 1'b1
  } rx_state_e;
endpackage

// File: rtl/irda_pulse_gen.sv
module irda_pulse_gen #(
  parameter int unsigned OSR   = irda_pkg::OSR_DEF,
  parameter int unsigned WIDTH = 8
) (
  input  logic [$clog2(OSR)-1:0] cell_pos,
  input  logic                   cell_zero,
  input  logic                   sending,
  input  logic                   width_var,
  input  logic [WIDTH-1:0]       width_val,
  output logic                   pulse
);
  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned MID = OSR / 2;
  localparam int unsigned EW  = (WIDTH > CW ? WIDTH : CW) + 1;

  logic [EW-1:0] width_eff;
  logic [EW-1:0] offset;
  logic          in_second_half;

  always_comb begin
    if (!width_var)
      width_eff = EW'(irda_pkg::FIXED_WIDTH);
    else if (width_val == '0)
      width_eff = EW'(1);
    else
      width_eff = EW'(width_val);
  end

  assign in_second_half = (cell_pos >= CW'(MID));
  assign offset         = EW'(cell_pos) - EW'(MID);
  assign pulse          = sending && cell_zero && in_second_half && (offset < width_eff);
endmodule

// File: rtl/irda_tx.sv
module irda_tx #(
  parameter int unsigned OSR   = irda_pkg::OSR_DEF,
  parameter int unsigned WIDTH = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              baud_tick,
  input  logic                              width_var,
  input  logic [WIDTH-1:0]                  width_val,
  input  logic [irda_pkg::DATA_BITS-1:0]    in_data,
  input  logic                              in_valid,
  output logic                              in_ready,
  output logic                              ir_out
);
  import irda_pkg::*;
  localparam int unsigned CW = $clog2(OSR);

  logic                    busy_q;
  logic [FRAME_CELLS-1:0]  cells_q;
  logic [CELL_IDX_W-1:0]   cell_idx_q;
  logic [CW-1:0]           pos_q;
  logic                    cell_end;

  assign cell_end = busy_q && baud_tick && (pos_q == CW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cells_q    <= '1;
      cell_idx_q <= '0;
      pos_q      <= '0;
    end else if (!busy_q) begin
      if (in_valid) begin
        busy_q     <= 1'b1;
        cells_q    <= {1'b1, in_data, 1'b0};
        cell_idx_q <= '0;
        pos_q      <= '0;
      end
    end else if (cell_end) begin
      pos_q   <= '0;
      cells_q <= {1'b1, cells_q[FRAME_CELLS-1:1]};
      if (cell_idx_q == CELL_IDX_W'(FRAME_CELLS - 1))
        busy_q <= 1'b0;
      else
        cell_idx_q <= cell_idx_q + 1'b1;
    end else if (baud_tick) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign in_ready = !busy_q;

  irda_pulse_gen #(.OSR(OSR), .WIDTH(WIDTH)) u_shape (
    .cell_pos  (pos_q),
    .cell_zero (!cells_q[0]),
    .sending   (busy_q),
    .width_var (width_var),
    .width_val (width_val),
    .pulse     (ir_out)
  );
endmodule

// File: rtl/irda_rx_front.sv
module irda_rx_front (
  input  logic clk,
  input  logic rst_n,
  input  logic invert,
  input  logic line_in,
  output logic rise
);
  logic s1_q, s2_q, act_d_q, act;

  assign act = s2_q ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      act_d_q <= 1'b1;
    end else begin
      s1_q    <= line_in;
      s2_q    <= s1_q;
      act_d_q <= act;
    end
  end

  assign rise = act && !act_d_q;
endmodule

// File: rtl/irda_rx.sv
module irda_rx #(
  parameter int unsigned OSR = irda_pkg::OSR_DEF
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           baud_tick,
  input  logic                           rise,
  output logic [irda_pkg::DATA_BITS-1:0] out_data,
  output logic                           out_valid,
  output logic                           out_err
);
  import irda_pkg::*;
  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned MID = OSR / 2;

  rx_state_e              state_q;
  logic [CW-1:0]          pos_q;
  logic [CELL_IDX_W-1:0]  cell_idx_q;
  logic                   seen_q;
  logic [DATA_BITS-1:0]   shift_q;
  logic                   cell_end;
  logic                   is_data_cell;
  logic                   is_stop_cell;

  assign cell_end     = (state_q == RX_CELL) && baud_tick && (pos_q == CW'(OSR - 1));
  assign is_stop_cell = (cell_idx_q == CELL_IDX_W'(FRAME_CELLS - 1));
  assign is_data_cell = (cell_idx_q != '0) && !is_stop_cell;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_HUNT;
      pos_q      <= '0;
      cell_idx_q <= '0;
      seen_q     <= 1'b0;
      shift_q    <= '0;
      out_data   <= '0;
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      case (state_q)
        RX_HUNT: begin
          if (rise) begin
            state_q    <= RX_CELL;
            pos_q      <= CW'(MID);
            cell_idx_q <= '0;
            seen_q     <= 1'b1;
          end
        end
        default: begin
          if (cell_end) begin
            pos_q  <= '0;
            seen_q <= rise;
            if (is_data_cell)
              shift_q <= {!seen_q, shift_q[DATA_BITS-1:1]};
            if (is_stop_cell) begin
              state_q   <= RX_HUNT;
              out_valid <= 1'b1;
              out_err   <= seen_q;
              out_data  <= shift_q;
            end else begin
              cell_idx_q <= cell_idx_q + 1'b1;
            end
          end else begin
            if (baud_tick)
              pos_q <= pos_q + 1'b1;
            if (rise)
              seen_q <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/irda_sir_modem.sv
module irda_sir_modem #(
  parameter int unsigned OSR   = irda_pkg::OSR_DEF,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             cfg_width_var,
  input  logic [WIDTH-1:0] cfg_width,
  input  logic             cfg_rx_invert,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             ir_tx,
  input  logic             ir_rx,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_frm_err
);
  logic rx_rise;

  irda_tx #(.OSR(OSR), .WIDTH(WIDTH)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .width_var (cfg_width_var),
    .width_val (cfg_width),
    .in_data   (tx_data),
    .in_valid  (tx_valid),
    .in_ready  (tx_ready),
    .ir_out    (ir_tx)
  );

  irda_rx_front u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .invert  (cfg_rx_invert),
    .line_in (ir_rx),
    .rise    (rx_rise)
  );

  irda_rx #(.OSR(OSR)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .rise      (rx_rise),
    .out_data  (rx_data),
    .out_valid (rx_valid),
    .out_err   (rx_frm_err)
  );
endmodule

// File: rtl/irda_sir_modem_chk.sv
module irda_sir_modem_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             baud_tick,
  input logic             cfg_width_var,
  input logic [WIDTH-1:0] cfg_width,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             ir_tx,
  input logic             rx_valid,
  input logic             rx_frm_err
);
  logic [WIDTH:0] hi_ticks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hi_ticks_q <= '0;
    else if (ir_tx)
      hi_ticks_q <= hi_ticks_q + (WIDTH+1)'(baud_tick);
    else
      hi_ticks_q <= '0;
  end

  p_take_drops_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_idle_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !ir_tx);

  p_fixed_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ir_tx) && !cfg_width_var) |-> (hi_ticks_q == (WIDTH+1)'(3)));

  p_prog_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ir_tx) && cfg_width_var && cfg_width != '0 && cfg_width <= WIDTH'(8))
      |-> (hi_ticks_q == (WIDTH+1)'(cfg_width)));

  p_cell_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ir_tx) |-> (hi_ticks_q <= (WIDTH+1)'(8)));

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_err_with_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frm_err |-> rx_valid);
endmodule

bind irda_sir_modem irda_sir_modem_chk #(.WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .baud_tick     (baud_tick),
  .cfg_width_var (cfg_width_var),
  .cfg_width     (cfg_width),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .ir_tx         (ir_tx),
  .rx_valid      (rx_valid),
  .rx_frm_err    (rx_frm_err)
);

// File: tb/irda_sir_modem_tb_top.sv
`timescale 1ns/1ps
module irda_sir_modem_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       cfg_width_var = 1'b0;
  logic [7:0] cfg_width = 8'd0;
  logic       cfg_rx_invert = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, ir_tx, ir_rx, rx_valid, rx_frm_err;
  logic [7:0] rx_data;
  logic       loop_en = 1'b1;
  logic       man_line = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign ir_rx = loop_en ? (ir_tx ^ cfg_rx_invert) : man_line;

  irda_sir_modem dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_width_var(cfg_width_var), .cfg_width(cfg_width), .cfg_rx_invert(cfg_rx_invert),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .ir_tx(ir_tx),
    .ir_rx(ir_rx), .rx_data(rx_data), .rx_valid(rx_valid), .rx_frm_err(rx_frm_err)
  );

  // baud strobe every 4 clocks, changed away from the sampling edge
  int div = 0;
  always @(negedge clk) begin
    div = (div + 1) % 4;
    baud_tick <= (div == 0);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: frame as a flat count of ticks
  bit        m_busy = 0;
  int        m_t = 0;
  logic [9:0] m_frame = '1;
  logic [8:0] exp_q[$];
  bit        btb = 0;
  int        btb_ready = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_t = 0;
    end else begin
      if (btb && tx_ready) btb_ready++;
      if (m_busy) begin
        if (baud_tick) begin
          m_t++;
          if (m_t == 160) m_busy = 0;
        end
      end else if (tx_valid) begin
        m_busy = 1; m_t = 0; m_frame = {1'b1, tx_data, 1'b0};
        if (loop_en) exp_q.push_back({1'b0, tx_data});
      end
    end
  end

  function automatic bit exp_pulse();
    int pos, w;
    pos = m_t % 16;
    if (!cfg_width_var) w = 3;
    else if (cfg_width == 0) w = 1;
    else w = cfg_width;
    return m_busy && !m_frame[m_t/16] && pos >= 8 && (pos - 8) < w;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tag;
      bit e;
      e = exp_pulse();
      if (!m_busy || m_frame[m_t/16]) tag = "R2";
      else if (!cfg_width_var) tag = "R3";
      else if (cfg_width > 8) tag = "R5";
      else tag = "R4";
      check(ir_tx === e, tag, ir_tx, e);
      check(tx_ready === !m_busy, "R1", tx_ready, !m_busy);
      if (rx_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected strobe", rx_data, 0);
        end else begin
          logic [8:0] x;
          x = exp_q.pop_front();
          tag = x[8] ? "R9" : (cfg_rx_invert ? "R8" : "R7");
          check(rx_data === x[7:0], tag, rx_data, x[7:0]);
          check(rx_frm_err === x[8], x[8] ? "R9" : "R9 no error", rx_frm_err, x[8]);
        end
      end
    end
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!baud_tick) @(posedge clk);
    end
  endtask

  task automatic do_reset(input bit inv);
    @(negedge clk);
    rst_n = 0;
    cfg_rx_invert = inv;
    man_line = inv;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    tx_data = b; tx_valid = 1;
    @(posedge clk);
    while (!tx_ready) @(posedge clk);
    @(negedge clk);
    tx_valid = 0;
    @(posedge clk);
    while (!tx_ready) @(posedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic man_frame(input logic [7:0] b, input bit stop_pulse);
    logic [9:0] f;
    f = {!stop_pulse, b, 1'b0};
    exp_q.push_back({stop_pulse, b});
    for (int c = 0; c < 10; c++) begin
      wait_ticks(8);
      if (!f[c]) begin
        @(negedge clk) man_line = !cfg_rx_invert;
        wait_ticks(2);
        @(negedge clk) man_line = cfg_rx_invert;
        wait_ticks(6);
      end else begin
        wait_ticks(8);
      end
    end
    repeat (16) @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(0);
    // R1/R2/R7: reset state
    check(tx_ready === 1'b1, "R1 reset ready", tx_ready, 1);
    check(ir_tx === 1'b0, "R2 reset dark", ir_tx, 0);
    check(rx_valid === 1'b0, "R7 reset strobe", rx_valid, 0);

    // R3, R7: fixed width loopback with assorted patterns
    send(8'h00); send(8'hFF); send(8'hA5); send(8'h3C);

    // R4: programmed widths, including zero
    cfg_width_var = 1;
    cfg_width = 8'd5;   send(8'h5A);
    cfg_width = 8'd0;   send(8'h81);
    cfg_width = 8'd8;   send(8'h66);
    // R5: widths past the cell end
    cfg_width = 8'd12;  send(8'h00);
    cfg_width = 8'd200; send(8'h42);
    cfg_width_var = 0;

    // R6: back-to-back with valid held high
    @(negedge clk);
    btb = 1; btb_ready = 0;
    tx_valid = 1; tx_data = 8'h11;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      while (!tx_ready) @(posedge clk);
      @(negedge clk);
      tx_data = (k == 0) ? 8'hE7 : 8'h29;
      if (k == 2) begin tx_valid = 0; btb = 0; end
    end
    check(btb_ready == 3, "R6 ready cycles", btb_ready, 3);
    @(posedge clk);
    while (!tx_ready) @(posedge clk);
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, "R7 all bytes delivered", exp_q.size(), 0);

    // R8: inverted polarity, loopback
    do_reset(1);
    send(8'h96); send(8'h01);

    // R9: scripted frames with and without a stop-cell pulse
    do_reset(0);
    loop_en = 0;
    man_frame(8'hC3, 1'b1);
    man_frame(8'h7E, 1'b0);
    // R8 + R9: inverted scripted frames
    do_reset(1);
    man_frame(8'h5B, 1'b1);
    man_frame(8'hF0, 1'b0);

    check(exp_q.size() == 0, "R9 all scripted bytes delivered", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule